// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Byte-Interface Controller

This block sequences an external multi-channel, 16-bit, simultaneous-sampling analog-to-digital converter through its 8-bit parallel byte bus. A rate counter paces conversions. Each conversion is started by a low pulse that is driven onto both start lines in the same cycle. The rising edge of that pulse samples every channel at one instant, so all channels share a common phase.

After the start pulse, the controller waits for the converter's busy line to rise and then fall. It then holds chip-select low and issues two read strobes per channel. The first strobe returns the high byte and the second returns the low byte. Each rebuilt word leaves on a one-cycle valid stream tagged with its channel index, ready for a downstream buffer. The first-data flag from the converter is checked on the first byte of every frame.

The static configuration outputs are held constant: parallel interface, byte mode, the ±5 V input range, and no oversampling. Three sticky flags report a busy timeout, a channel misalignment, and a start that fell due while a frame was still being read.

Top module: `adc_byte_ctrl`

## Requirements
- R1: The configuration outputs are constant from reset on: `par_ser_o`=1, `byte_sel_o`=1, `range_o`=0, `os_o`=3'b000.
- R2: `convst_a_o` and `convst_b_o` are equal in every cycle. They idle high and go low together for `PULSE_W` cycles per conversion.
- R3: While `enable_i` is high, conversion starts fall every max(`rate_div_i`, `MIN_PERIOD`) cycles, provided each frame ends in time. While `enable_i` is low, no start is issued.
- R4: After a start, chip-select falls only once busy has been seen high and has then returned low.
- R5: Each read strobe stays low for `RD_LO_CYC` cycles. Between strobes it stays high for `RD_HI_CYC` cycles. The byte is captured at the end of the `SAMPLE_CYC`-th low cycle, so data that becomes valid one cycle after the strobe falls is still taken.
- R6: A frame has 2·`N_CH` strobes under one chip-select. Even strobes give bits 15:8 and odd strobes give bits 7:0. Words leave as single-cycle `smp_valid_o` pulses with `smp_chan_o` counting up from 0 to `N_CH`-1.
- R7: If first-data is low on the first byte of a frame, `misalign_o` goes high and stays high. That frame produces no valid pulse. The next aligned frame is delivered in full.
- R8: If busy does not complete its high-then-low cycle within `TIMEOUT_CYC` cycles of the wait starting, `busy_timeout_o` goes high and stays high. The frame ends without any strobe. Later frames work normally once busy behaves.
- R9: A start that falls due during a frame is held off until the frame ends and is then issued, and `overrun_o` goes high and stays high. A start is never low while chip-select is low.
- R10: During and right after reset, the start lines, chip-select and read are high, `smp_valid_o` is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run periodic conversions |
| rate_div_i | input | DIV_W | Conversion period in clock cycles |
| convst_a_o | output | 1 | Conversion start, channel group A |
| convst_b_o | output | 1 | Conversion start, channel group B |
| busy_i | input | 1 | Converter busy (asynchronous) |
| cs_no | output | 1 | Chip-select, active low |
| rd_no | output | 1 | Read strobe, active low |
| frstdata_i | input | 1 | High while the first byte of a frame is driven |
| db_i | input | 8 | Byte data bus |
| par_ser_o | output | 1 | Interface select, 1 = parallel |
| byte_sel_o | output | 1 | Byte-mode select, 1 = byte mode |
| range_o | output | 1 | Input range, 0 = ±5 V |
| os_o | output | 3 | Oversampling select, 0 = off |
| smp_valid_o | output | 1 | One-cycle word strobe |
| smp_data_o | output | 16 | Two's-complement sample |
| smp_chan_o | output | CH_W | Channel index of the sample |
| busy_timeout_o | output | 1 | Sticky busy-timeout flag |
| misalign_o | output | 1 | Sticky first-data misalignment flag |
| overrun_o | output | 1 | Sticky held-off-start flag |

## Verification
The bench sets `MIN_PERIOD` to 120 and `TIMEOUT_CYC` to 64, and keeps 8 channels with a 3/2-cycle strobe and a sample point in the second low cycle. A full frame then takes about 106 cycles when the modelled busy pulse lasts 20 cycles. With these values, three cases are reached within a few hundred cycles each: the period clamp (a divider of 50 runs at 120), an overrun (a 40-cycle busy stretches the frame past 120), and a timeout (a stuck busy exceeds 64). The converter model puts a junk byte on the bus in the first low cycle of each strobe, so capturing one cycle too early shows up as corrupt data.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_RD_LO,
    ST_RD_HI
  } seq_state_e;
endpackage

// File: rtl/adc_rate_gen.sv
module adc_rate_gen #(
  parameter int DIV_W      = 16,
  parameter int MIN_PERIOD = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] MinP = DIV_W'(MIN_PERIOD);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] per;
  logic             wrap;

  assign per    = (div_i < MinP) ? MinP : div_i;
  assign wrap   = cnt_q >= (per - 1'b1);
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (wrap)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  initial begin
    min_period_chk: assert (MIN_PERIOD >= 2) else $error("MIN_PERIOD below 2");
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq import adc_ctl_pkg::*; #(
  parameter int N_CH        = 8,
  parameter int PULSE_W     = 2,
  parameter int RD_LO_CYC   = 3,
  parameter int RD_HI_CYC   = 2,
  parameter int SAMPLE_CYC  = 2,
  parameter int TIMEOUT_CYC = 1000,
  localparam int N_BYTES    = 2 * N_CH,
  localparam int IDX_W      = $clog2(N_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic [7:0]       db_i,
  input  logic             frst_i,
  output logic             conv_n_o,
  output logic             cs_n_o,
  output logic             rd_n_o,
  output logic             idle_o,
  output logic             cap_o,
  output logic [7:0]       cap_byte_o,
  output logic [IDX_W-1:0] cap_idx_o,
  output logic             cap_frst_o,
  output logic             tmo_o
);
  localparam int M1    = (PULSE_W > RD_LO_CYC) ? PULSE_W : RD_LO_CYC;
  localparam int M2    = (RD_HI_CYC > M1) ? RD_HI_CYC : M1;
  localparam int CMAX  = (TIMEOUT_CYC > M2) ? TIMEOUT_CYC : M2;
  localparam int CNT_W = $clog2(CMAX + 1);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             tmo_hit;

  assign tmo_hit = cnt_q == CNT_W'(TIMEOUT_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      tmo_o <= 1'b0;
    end else begin
      tmo_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_i) st_q <= ST_CONV;
        end
        ST_CONV: begin
          if (cnt_q == CNT_W'(PULSE_W - 1)) begin
            st_q  <= ST_WAIT_HI;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_WAIT_HI, ST_WAIT_LO: begin
          if (st_q == ST_WAIT_LO && !busy_i) begin
            st_q  <= ST_RD_LO;
            cnt_q <= '0;
            idx_q <= '0;
          end else if (tmo_hit) begin
            st_q  <= ST_IDLE;
            tmo_o <= 1'b1;
          end else begin
            if (st_q == ST_WAIT_HI && busy_i) st_q <= ST_WAIT_LO;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RD_LO: begin
          if (cnt_q == CNT_W'(RD_LO_CYC - 1)) begin
            st_q  <= ST_RD_HI;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_RD_HI: begin
          if (cnt_q == CNT_W'(RD_HI_CYC - 1)) begin
            cnt_q <= '0;
            if (idx_q == IDX_W'(N_BYTES - 1)) st_q <= ST_IDLE;
            else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_RD_LO;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = st_q == ST_IDLE;
  assign conv_n_o   = st_q != ST_CONV;
  assign rd_n_o     = st_q != ST_RD_LO;
  assign cs_n_o     = !(st_q == ST_RD_LO || st_q == ST_RD_HI);
  assign cap_o      = (st_q == ST_RD_LO) && (cnt_q == CNT_W'(SAMPLE_CYC - 1));
  assign cap_byte_o = db_i;
  assign cap_idx_o  = idx_q;
  assign cap_frst_o = frst_i;

  initial begin
    rd_lo_min_chk:  assert (RD_LO_CYC >= 2) else $error("RD_LO_CYC below 2");
    rd_hi_min_chk:  assert (RD_HI_CYC >= 2) else $error("RD_HI_CYC below 2");
    sample_min_chk: assert (SAMPLE_CYC >= 2 && SAMPLE_CYC <= RD_LO_CYC)
      else $error("SAMPLE_CYC out of range");
  end

  // R4
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> !$past(busy_i));
  // R5
  cap_in_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> (!cs_n_o && !rd_n_o));
endmodule

// File: rtl/adc_word_pack.sv
module adc_word_pack #(
  parameter int N_CH     = 8,
  localparam int IDX_W   = $clog2(2 * N_CH),
  localparam int CH_W    = IDX_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [7:0]       cap_byte_i,
  input  logic [IDX_W-1:0] cap_idx_i,
  input  logic             cap_frst_i,
  output logic             vld_o,
  output logic [15:0]      data_o,
  output logic [CH_W-1:0]  ch_o,
  output logic             misal_o
);
  logic [7:0] hi_q;
  logic       drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      drop_q  <= 1'b0;
      vld_o   <= 1'b0;
      data_o  <= '0;
      ch_o    <= '0;
      misal_o <= 1'b0;
    end else begin
      vld_o   <= 1'b0;
      misal_o <= 1'b0;
      if (cap_i) begin
        if (!cap_idx_i[0]) begin
          hi_q <= cap_byte_i;
          if (cap_idx_i == '0) begin
            drop_q  <= !cap_frst_i;
            misal_o <= !cap_frst_i;
          end
        end else begin
          data_o <= {hi_q, cap_byte_i};
          ch_o   <= cap_idx_i[IDX_W-1:1];
          vld_o  <= !drop_q;
        end
      end
    end
  end

  // R6
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  // R7
  drop_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misal_o |=> !vld_o);
endmodule

// File: rtl/adc_byte_ctrl.sv
module adc_byte_ctrl #(
  parameter int N_CH        = 8,
  parameter int DIV_W       = 16,
  parameter int MIN_PERIOD  = 250,
  parameter int PULSE_W     = 2,
  parameter int RD_LO_CYC   = 3,
  parameter int RD_HI_CYC   = 2,
  parameter int SAMPLE_CYC  = 2,
  parameter int TIMEOUT_CYC = 1000,
  localparam int CH_W       = $clog2(N_CH),
  localparam int IDX_W      = $clog2(2 * N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [DIV_W-1:0] rate_div_i,
  output logic             convst_a_o,
  output logic             convst_b_o,
  input  logic             busy_i,
  output logic             cs_no,
  output logic             rd_no,
  input  logic             frstdata_i,
  input  logic [7:0]       db_i,
  output logic             par_ser_o,
  output logic             byte_sel_o,
  output logic             range_o,
  output logic [2:0]       os_o,
  output logic             smp_valid_o,
  output logic [15:0]      smp_data_o,
  output logic [CH_W-1:0]  smp_chan_o,
  output logic             busy_timeout_o,
  output logic             misalign_o,
  output logic             overrun_o
);
  logic [1:0]       busy_sync_q;
  logic             tick, seq_idle, start, pend_q, conv_n;
  logic             cap, cap_frst, tmo, misal;
  logic [7:0]       cap_byte;
  logic [IDX_W-1:0] cap_idx;

  // fixed strapping: parallel, byte mode, +/-5 V, no oversampling
  assign par_ser_o  = 1'b1;
  assign byte_sel_o = 1'b1;
  assign range_o    = 1'b0;
  assign os_o       = 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_sync_q <= '0;
    else         busy_sync_q <= {busy_sync_q[0], busy_i};
  end

  adc_rate_gen #(.DIV_W(DIV_W), .MIN_PERIOD(MIN_PERIOD)) u_rate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (enable_i),
    .div_i (rate_div_i),
    .tick_o(tick)
  );

  assign start = seq_idle && (tick || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q         <= 1'b0;
      overrun_o      <= 1'b0;
      busy_timeout_o <= 1'b0;
      misalign_o     <= 1'b0;
    end else begin
      if (!enable_i || start)   pend_q <= 1'b0;
      else if (tick && !seq_idle) pend_q <= 1'b1;
      if (tick && !seq_idle) overrun_o      <= 1'b1;
      if (tmo)               busy_timeout_o <= 1'b1;
      if (misal)             misalign_o     <= 1'b1;
    end
  end

  adc_read_seq #(
    .N_CH(N_CH), .PULSE_W(PULSE_W), .RD_LO_CYC(RD_LO_CYC), .RD_HI_CYC(RD_HI_CYC),
    .SAMPLE_CYC(SAMPLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .busy_i    (busy_sync_q[1]),
    .db_i      (db_i),
    .frst_i    (frstdata_i),
    .conv_n_o  (conv_n),
    .cs_n_o    (cs_no),
    .rd_n_o    (rd_no),
    .idle_o    (seq_idle),
    .cap_o     (cap),
    .cap_byte_o(cap_byte),
    .cap_idx_o (cap_idx),
    .cap_frst_o(cap_frst),
    .tmo_o     (tmo)
  );

  // same edge on both groups keeps all channels in phase
  assign convst_a_o = conv_n;
  assign convst_b_o = conv_n;

  adc_word_pack #(.N_CH(N_CH)) u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .cap_byte_i(cap_byte),
    .cap_idx_i (cap_idx),
    .cap_frst_i(cap_frst),
    .vld_o     (smp_valid_o),
    .data_o    (smp_data_o),
    .ch_o      (smp_chan_o),
    .misal_o   (misal)
  );

  // R9
  no_conv_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !convst_a_o |-> cs_no);
  // R9
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(overrun_o));
  // R8
  timeout_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_timeout_o));
  // R7
  misalign_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(misalign_o));
  // R3
  idle_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !pend_q && seq_idle) |=> convst_a_o);
endmodule

// File: tb/adc_byte_ctrl_tb.sv
module adc_byte_ctrl_tb;
  localparam int N_CH = 8;
  localparam int MINP = 120;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic [15:0] rate = 16'd150;
  logic        busy = 1'b0;
  logic        frst = 1'b0;
  logic [7:0]  db = 8'hEE;
  logic        conv_a, conv_b, cs_n, rd_n, par_ser, byte_sel, rng;
  logic [2:0]  os;
  logic        vld;
  logic [15:0] data;
  logic [2:0]  chan;
  logic        f_tmo, f_mis, f_ovr;

  int nchk = 0, nbad = 0;
  int cyc = 0, nfall = 0, last_fall = 0, period = 0, conv_mis = 0, conv_in_cs = 0;
  int cs_falls = 0, vcount = 0, exp_ch = 0, lo_run = 0, hi_run = 0;
  int frame_no = 0, rd_cnt = 0, busy_len = 20;
  bit busy_seen = 0, stuck = 0, frst_bad = 0;
  logic prev_conv = 1'b1, prev_cs = 1'b1, prev_rd = 1'b1;

  always #10 clk = ~clk;

  adc_byte_ctrl #(.N_CH(N_CH), .MIN_PERIOD(MINP), .TIMEOUT_CYC(64)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(en), .rate_div_i(rate),
    .convst_a_o(conv_a), .convst_b_o(conv_b), .busy_i(busy), .cs_no(cs_n), .rd_no(rd_n),
    .frstdata_i(frst), .db_i(db), .par_ser_o(par_ser), .byte_sel_o(byte_sel),
    .range_o(rng), .os_o(os), .smp_valid_o(vld), .smp_data_o(data), .smp_chan_o(chan),
    .busy_timeout_o(f_tmo), .misalign_o(f_mis), .overrun_o(f_ovr)
  );

  function automatic logic [15:0] word_of(int f, int c);
    return 16'h8000 ^ 16'((f * 37) << 3) ^ 16'(c * 16'h1357);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model: busy after start edge
  always @(posedge conv_a) begin
    if (rst_ni) begin
      frame_no = frame_no + 1;
      @(posedge clk); #1 busy = 1'b1;
      repeat (busy_len) @(posedge clk);
      #1 if (!stuck) busy = 1'b0;
    end
  end

  // converter model: junk byte in first low cycle, real byte after
  always @(negedge rd_n) begin
    if (rst_ni) begin
      automatic int idx = rd_cnt;
      rd_cnt = (rd_cnt == 2 * N_CH - 1) ? 0 : rd_cnt + 1;
      db   = 8'hEE;
      frst = (idx == 0) && !frst_bad;
      @(posedge clk); #1;
      db = idx[0] ? word_of(frame_no, idx / 2)[7:0] : word_of(frame_no, idx / 2)[15:8];
      @(posedge rd_n);
      db   = 8'hEE;
      frst = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (conv_a !== conv_b) conv_mis++;
      if (prev_conv && !conv_a) begin
        if (nfall > 0) period = cyc - last_fall;
        last_fall = cyc;
        nfall++;
        busy_seen = 0;
      end
      if (busy) busy_seen = 1;
      if (!conv_a && !cs_n) conv_in_cs++;
      if (prev_cs && !cs_n) begin
        cs_falls++;
        exp_ch = 0;
        chk(busy_seen && !busy, "R4", "busy rise/fall before chip-select", busy_seen, 1);
      end
      if (!prev_cs && cs_n) hi_run = 0;
      if (!rd_n) lo_run++;
      else if (!cs_n) hi_run++;
      if (!prev_rd && rd_n) begin
        chk(lo_run == 3, "R5", "read low cycles", lo_run, 3);
        lo_run = 0;
      end
      if (prev_rd && !rd_n) begin
        if (hi_run != 0) chk(hi_run == 2, "R5", "read high cycles", hi_run, 2);
        hi_run = 0;
      end
      if (vld) begin
        chk(chan == 3'(exp_ch), "R6", "channel index", chan, exp_ch);
        chk(data == word_of(frame_no, exp_ch), "R6", "word", data, word_of(frame_no, exp_ch));
        exp_ch++;
        vcount++;
      end
      prev_conv = conv_a;
      prev_cs   = cs_n;
      prev_rd   = rd_n;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_frame();
    @(negedge cs_n);
    @(posedge cs_n);
    @(negedge clk);
  endtask

  task automatic t_reset();
    wait_cyc(2);
    chk(conv_a && conv_b, "R10", "start lines idle", conv_a, 1);
    chk(cs_n && rd_n, "R10", "select/read idle", {cs_n, rd_n}, 3);
    chk(!vld && !f_tmo && !f_mis && !f_ovr, "R10", "valid/flags", {vld, f_tmo, f_mis, f_ovr}, 0);
    chk(par_ser && byte_sel, "R1", "mode pins", {par_ser, byte_sel}, 3);
    chk(!rng && os == 3'b000, "R1", "range/oversample", {rng, os}, 0);
  endtask

  task automatic t_normal();
    int v0 = vcount;
    rate = 16'd150;
    en = 1'b1;
    wait_cyc(5 * 150 + 20);
    chk(period == 150, "R3", "start period", period, 150);
    chk(vcount - v0 >= 32, "R6", "words delivered", vcount - v0, 32);
    chk(conv_mis == 0, "R2", "start line mismatches", conv_mis, 0);
    chk(!f_ovr && !f_tmo && !f_mis, "R9", "no flag in normal run", {f_ovr, f_tmo, f_mis}, 0);
    chk(par_ser && byte_sel && !rng && os == 0, "R1", "pins while running", {par_ser, byte_sel}, 3);
  endtask

  task automatic t_min_period();
    en = 1'b0;
    wait_cyc(300);
    rate = 16'd50;
    en = 1'b1;
    wait_cyc(5 * MINP + 20);
    chk(period == MINP, "R3", "clamped period", period, MINP);
    chk(!f_ovr, "R9", "no overrun at clamp", f_ovr, 0);
  endtask

  task automatic t_disable();
    int n0;
    en = 1'b0;
    wait_cyc(200);
    n0 = nfall;
    wait_cyc(400);
    chk(nfall == n0, "R3", "starts while disabled", nfall - n0, 0);
    chk(conv_a && conv_b, "R2", "start lines high while disabled", conv_a, 1);
  endtask

  task automatic t_misalign();
    int v0;
    rate = 16'd150;
    frst_bad = 1;
    v0 = vcount;
    en = 1'b1;
    wait_frame();
    frst_bad = 0;
    chk(f_mis == 1'b1, "R7", "misalign flag", f_mis, 1);
    chk(vcount == v0, "R7", "words from misaligned frame", vcount - v0, 0);
    v0 = vcount;
    wait_frame();
    chk(vcount - v0 == N_CH, "R7", "words after realign", vcount - v0, N_CH);
    chk(f_mis == 1'b1, "R7", "misalign stays set", f_mis, 1);
    en = 1'b0;
    wait_cyc(300);
  endtask

  task automatic t_timeout();
    int c0, v0;
    stuck = 1;
    c0 = cs_falls;
    en = 1'b1;
    wait_cyc(400);
    chk(f_tmo == 1'b1, "R8", "timeout flag", f_tmo, 1);
    chk(cs_falls == c0, "R8", "reads during stuck busy", cs_falls - c0, 0);
    en = 1'b0;
    wait_cyc(200);
    stuck = 0;
    busy = 1'b0;
    wait_cyc(5);
    v0 = vcount;
    en = 1'b1;
    wait_frame();
    chk(vcount - v0 == N_CH, "R8", "words after recovery", vcount - v0, N_CH);
    chk(f_tmo == 1'b1, "R8", "timeout stays set", f_tmo, 1);
    en = 1'b0;
    wait_cyc(300);
  endtask

  task automatic t_overrun();
    int n0, v0;
    busy_len = 40;
    rate = 16'd120;
    n0 = nfall;
    v0 = vcount;
    en = 1'b1;
    wait_cyc(900);
    chk(f_ovr == 1'b1, "R9", "overrun flag", f_ovr, 1);
    chk(period > 120, "R9", "held-off start spacing", period, 121);
    chk(nfall - n0 >= 5, "R9", "held-off starts still issued", nfall - n0, 5);
    chk(conv_in_cs == 0, "R9", "start during read", conv_in_cs, 0);
    chk(vcount - v0 >= 4 * N_CH, "R6", "words under overrun", vcount - v0, 4 * N_CH);
    en = 1'b0;
    wait_cyc(300);
  endtask

  initial begin
    wait_cyc(5);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_normal();
    t_min_period();
    t_disable();
    t_misalign();
    t_timeout();
    t_overrun();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", cyc, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule